// File: doc/BRIEF.md
# Synchronous Receive Input Conditioner

This block sits between three external serial pins (data, receive clock and carrier-detect) and a synchronous receiver that runs on the system clock. It brings every pin into the system clock domain and applies a control byte. The byte can invert the data, pick the receive-clock edge that counts, and let clock edges through only while carrier-detect is at a chosen active level. It can also shut all three inputs off. The block delivers one conditioned data bit and a one-cycle strobe for each accepted receive-clock edge. The receiver's shift register and the baud generator are outside this block.

A two-bit mode input selects one of three datapaths. In normal operation the pins feed the receiver. In echo operation they also feed the receiver, and the three raw pins are copied straight to the serial, clock and request-to-send outputs. In loopback the receiver takes its data and clock from the local transmitter, and the pins and all polarity controls are bypassed. Outside echo operation the three outputs pass the transmitter's data, clock and request-to-send signals through.

A path state machine chooses among four states, each decided from the mode input and the effective control byte with a fixed priority. ST_LOOP is taken whenever loopback is requested. ST_MUTED is taken when inputs are disabled and loopback is not requested. ST_ECHO is taken when echo is requested and neither of the first two applies. ST_DIRECT covers every other case. The state can move directly from any of these states to any other. A second machine gates the receive clock. It moves from GATE_OPEN to GATE_SHUT when carrier gating is on and the synchronized carrier sample is inactive. It moves from GATE_SHUT back to GATE_OPEN when the carrier becomes active or gating is switched off.

Top module: `srx_input_conditioner`

## Requirements
- R1: Reset loads the control byte with 0x03, puts the path machine in ST_DIRECT and drives rx_data_o high and rx_strobe_o low. With that byte, data passes uninverted, rising receive-clock edges count, and no carrier gating applies.
- R2: While control bit 7 (synchronous enable) is 0, bits 6 to 2 have no effect, and the block behaves as if all of them were 0.
- R3: Pin values reach the receiver through two synchronizer flops. After system edge n, rx_data_o equals the pin data sampled at edge n-2, XORed with control bit 6 (data invert).
- R4: Control bit 5 selects the receive-clock edge: 0 counts rising edges and 1 counts falling edges. After system edge n, rx_strobe_o is high for exactly one cycle when the synchronized clock samples of edges n-3 and n-2 form the selected edge.
- R5: When control bit 4 is set, a clock edge produces a strobe only if the carrier sample from edge n-3 is at its active level. Control bit 3 selects that level: 0 means active-low and 1 means active-high.
- R6: When control bit 2 (input disable) is set and loopback is not selected, rx_data_o is held high and no strobe occurs. In this state the outputs carry the transmitter signals even if echo is requested.
- R7: In echo mode (mode_i = 2'b01) without input disable, sout_o, clkout_o and rts_o copy pin_din_i, pin_rxclk_i and pin_dcd_i combinationally, whatever control bits 6 to 3 hold. In all other states these outputs copy tx_data_i, tx_clk_i and tx_rts_i.
- R8: In loopback (mode_i = 2'b10 or 2'b11), after edge n rx_data_o equals tx_data_i sampled at edge n. rx_strobe_o is high when tx_clk_i was 0 at edge n-1 and 1 at edge n. Control bits 6 to 2 have no effect in loopback.
- R9: The path states are chosen in the priority order loopback first, then input disable, then echo, then direct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Write strobe for the control byte |
| cfg_wdata_i | input | 8 | New control byte |
| mode_i | input | 2 | 00 normal, 01 echo, 1x loopback |
| pin_din_i | input | 1 | Serial data pin |
| pin_rxclk_i | input | 1 | Receive clock pin |
| pin_dcd_i | input | 1 | Carrier-detect pin |
| tx_data_i | input | 1 | Local transmitter data |
| tx_clk_i | input | 1 | Local transmitter clock |
| tx_rts_i | input | 1 | Local request-to-send |
| rx_data_o | output | 1 | Conditioned receive data |
| rx_strobe_o | output | 1 | One-cycle strobe for each accepted receive-clock edge |
| sout_o | output | 1 | Serial data output |
| clkout_o | output | 1 | Clock output |
| rts_o | output | 1 | Request-to-send output |

## Verification
The bench targets the cases where a control bit must be ignored. These are polarity bits set together with synchronous enable cleared, every polarity bit set during echo and loopback, and input disable set together with loopback or echo. A design that applied a polarity bit on one of these paths would invert echoed or looped data, or would drop and duplicate strobes. A design with the wrong mode priority would mute loopback, or would echo pins while inputs are disabled. Carrier gating is run with both active levels, because a reversed polarity test passes clock edges exactly while the carrier is inactive. Random segments check the synchronizer latency and the edge alignment cycle by cycle, so an extra or missing flop would be detected.

// File: rtl/srx_pkg.sv
`timescale 1ns/1ps
package srx_pkg;

    localparam int CFG_W        = 8;
    localparam int BIT_SYNC_EN  = 7;
    localparam int BIT_DATA_INV = 6;
    localparam int BIT_CLK_FALL = 5;
    localparam int BIT_CD_EN    = 4;
    localparam int BIT_CD_HIGH  = 3;
    localparam int BIT_IN_OFF   = 2;
    localparam int CFG_LOW_USED = BIT_IN_OFF;

    localparam int MODE_W        = 2;
    localparam int MODE_ECHO_BIT = 0;
    localparam int MODE_LOOP_BIT = 1;

    typedef enum logic [1:0] {
        ST_DIRECT = 2'd0,
        ST_ECHO   = 2'd1,
        ST_LOOP   = 2'd2,
        ST_MUTED  = 2'd3
    } path_state_t;

    typedef enum logic {
        GATE_SHUT = 1'b0,
        GATE_OPEN = 1'b1
    } gate_state_t;

endpackage

// File: rtl/srx_pin_sync.sv
`timescale 1ns/1ps
module srx_pin_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] din_i,
    output logic [WIDTH-1:0] dout_o
);

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            chain_q <= {STAGES{RESET_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], din_i};
        end
    end

    assign dout_o = chain_q[STAGES-1];

    // cycles since reset, saturating, so that $past never reaches before it
    logic [1:0] warm_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            warm_q <= 2'd0;
        end else if (warm_q != 2'd3) begin
            warm_q <= warm_q + 2'd1;
        end
    end

    generate
        if (STAGES == 2) begin : g_chk2
            assert_sync_latency_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (warm_q >= 2'd2) |-> (dout_o == $past(din_i, 2)));
        end
    endgenerate

endmodule

// File: rtl/srx_cd_gate.sv
`timescale 1ns/1ps
module srx_cd_gate
    import srx_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic cd_sync_i,
    input  logic cd_en_i,
    input  logic cd_high_i,
    output logic open_o
);

    gate_state_t state_q, state_d;
    logic        cd_active;

    assign cd_active = (cd_sync_i == cd_high_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= GATE_OPEN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            GATE_SHUT: state_d = (!cd_en_i || cd_active) ? GATE_OPEN : GATE_SHUT;
            GATE_OPEN: state_d = (cd_en_i && !cd_active) ? GATE_SHUT : GATE_OPEN;
            default:   state_d = GATE_OPEN;
        endcase
    end

    assign open_o = (state_q == GATE_OPEN);

    assert_gate_shuts_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cd_en_i && (cd_sync_i != cd_high_i)) |=> !open_o);

    assert_gate_bypass_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cd_en_i) |=> open_o);

endmodule

// File: rtl/srx_path_fsm.sv
`timescale 1ns/1ps
module srx_path_fsm
    import srx_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [MODE_W-1:0]   mode_i,
    input  logic                in_off_i,
    input  logic                data_inv_i,
    input  logic                clk_fall_i,
    input  logic                din_sync_i,
    input  logic                clk_sync_i,
    input  logic                gate_open_i,
    input  logic                tx_data_i,
    input  logic                tx_clk_i,
    output path_state_t         state_o,
    output logic                rx_data_o,
    output logic                rx_strobe_o
);

    path_state_t state_q, state_d;
    logic        clk_prev_q;
    logic        tx_clk_q;
    logic        pin_edge;
    logic        tx_rise;

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_DIRECT;
        end else begin
            state_q <= state_d;
        end
    end

    // next state: loopback over mute over echo over direct
    always_comb begin
        if (mode_i[MODE_LOOP_BIT]) begin
            state_d = ST_LOOP;
        end else if (in_off_i) begin
            state_d = ST_MUTED;
        end else if (mode_i[MODE_ECHO_BIT]) begin
            state_d = ST_ECHO;
        end else begin
            state_d = ST_DIRECT;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            clk_prev_q <= 1'b0;
            tx_clk_q   <= 1'b0;
        end else begin
            clk_prev_q <= clk_sync_i;
            tx_clk_q   <= tx_clk_i;
        end
    end

    assign pin_edge = clk_fall_i ? (clk_prev_q & ~clk_sync_i)
                                 : (~clk_prev_q & clk_sync_i);
    assign tx_rise  = tx_clk_i & ~tx_clk_q;

    // outputs
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rx_data_o   <= 1'b1;
            rx_strobe_o <= 1'b0;
        end else begin
            unique case (state_q)
                ST_LOOP: begin
                    rx_data_o   <= tx_data_i;
                    rx_strobe_o <= tx_rise;
                end
                ST_MUTED: begin
                    rx_data_o   <= 1'b1;
                    rx_strobe_o <= 1'b0;
                end
                ST_DIRECT, ST_ECHO: begin
                    rx_data_o   <= din_sync_i ^ data_inv_i;
                    rx_strobe_o <= pin_edge & gate_open_i;
                end
                default: begin
                    rx_data_o   <= 1'b1;
                    rx_strobe_o <= 1'b0;
                end
            endcase
        end
    end

    assign state_o = state_q;

    assert_muted_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_MUTED) |=> (rx_data_o && !rx_strobe_o));

    assert_loop_data_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_LOOP) |=> (rx_data_o == $past(tx_data_i)));

    assert_gate_blocks_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((state_q != ST_LOOP) && !gate_open_i) |=> !rx_strobe_o);

endmodule

// File: rtl/srx_input_conditioner.sv
`timescale 1ns/1ps
module srx_input_conditioner
    import srx_pkg::*;
#(
    parameter int              SYNC_STAGES = 2,
    parameter logic [CFG_W-1:0] CFG_RESET  = 8'h03
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cfg_we_i,
    input  logic [CFG_W-1:0]  cfg_wdata_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              pin_din_i,
    input  logic              pin_rxclk_i,
    input  logic              pin_dcd_i,
    input  logic              tx_data_i,
    input  logic              tx_clk_i,
    input  logic              tx_rts_i,
    output logic              rx_data_o,
    output logic              rx_strobe_o,
    output logic              sout_o,
    output logic              clkout_o,
    output logic              rts_o
);

    localparam int KEEP_W   = CFG_W - CFG_LOW_USED;
    localparam int PIN_N    = 3;
    localparam int IDX_DIN  = 0;
    localparam int IDX_CLK  = 1;
    localparam int IDX_CD   = 2;
    localparam logic [PIN_N-1:0] PIN_IDLE = 3'b101;

    logic [KEEP_W-1:0] cfg_q;
    logic              cfg_unused;
    logic              sync_en;
    logic              eff_inv, eff_fall, eff_cd_en, eff_cd_high, eff_off;
    logic [PIN_N-1:0]  pins_raw, pins_sync;
    logic              gate_open;
    path_state_t       path_state;

    assign cfg_unused = ^cfg_wdata_i[CFG_LOW_USED-1:0];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q <= CFG_RESET[CFG_W-1:CFG_LOW_USED];
        end else if (cfg_we_i) begin
            cfg_q <= cfg_wdata_i[CFG_W-1:CFG_LOW_USED];
        end
    end

    // with synchronous enable clear every feature bit reads as zero
    assign sync_en     = cfg_q[BIT_SYNC_EN  - CFG_LOW_USED];
    assign eff_inv     = sync_en & cfg_q[BIT_DATA_INV - CFG_LOW_USED];
    assign eff_fall    = sync_en & cfg_q[BIT_CLK_FALL - CFG_LOW_USED];
    assign eff_cd_en   = sync_en & cfg_q[BIT_CD_EN    - CFG_LOW_USED];
    assign eff_cd_high = sync_en & cfg_q[BIT_CD_HIGH  - CFG_LOW_USED];
    assign eff_off     = sync_en & cfg_q[BIT_IN_OFF   - CFG_LOW_USED];

    assign pins_raw[IDX_DIN] = pin_din_i;
    assign pins_raw[IDX_CLK] = pin_rxclk_i;
    assign pins_raw[IDX_CD]  = pin_dcd_i;

    srx_pin_sync #(
        .WIDTH    (PIN_N),
        .STAGES   (SYNC_STAGES),
        .RESET_VAL(PIN_IDLE)
    ) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .din_i (pins_raw),
        .dout_o(pins_sync)
    );

    srx_cd_gate u_gate (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .cd_sync_i(pins_sync[IDX_CD]),
        .cd_en_i  (eff_cd_en),
        .cd_high_i(eff_cd_high),
        .open_o   (gate_open)
    );

    srx_path_fsm u_path (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .mode_i     (mode_i),
        .in_off_i   (eff_off),
        .data_inv_i (eff_inv),
        .clk_fall_i (eff_fall),
        .din_sync_i (pins_sync[IDX_DIN]),
        .clk_sync_i (pins_sync[IDX_CLK]),
        .gate_open_i(gate_open),
        .tx_data_i  (tx_data_i),
        .tx_clk_i   (tx_clk_i),
        .state_o    (path_state),
        .rx_data_o  (rx_data_o),
        .rx_strobe_o(rx_strobe_o)
    );

    // echo paths carry raw pins, untouched by any polarity bit
    always_comb begin
        if (path_state == ST_ECHO) begin
            sout_o   = pin_din_i;
            clkout_o = pin_rxclk_i;
            rts_o    = pin_dcd_i;
        end else begin
            sout_o   = tx_data_i;
            clkout_o = tx_clk_i;
            rts_o    = tx_rts_i;
        end
    end

    assert_loop_no_mute_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i[MODE_LOOP_BIT]) |=> (path_state == ST_LOOP));

endmodule

// File: tb/srx_input_conditioner_tb_top.sv
`timescale 1ns/1ps
module srx_input_conditioner_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [1:0] mode = 2'b00;
    logic       pin_din = 1'b1, pin_rxclk = 1'b0, pin_dcd = 1'b1;
    logic       tx_data = 1'b0, tx_clk = 1'b0, tx_rts = 1'b0;
    logic       rx_data, rx_strobe, sout, clkout, rts;

    int errors = 0;
    int checks = 0;
    logic [7:0] cur_cfg = 8'h03;
    logic [1:0] cur_mode = 2'b00;

    logic [3:0] h_din = '0, h_clk = '0, h_cd = '0;
    logic [1:0] h_tclk = '0;
    logic       h_tdata = 1'b0;

    always #2.5 clk = ~clk;

    srx_input_conditioner dut_i (
        .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
        .mode_i(mode), .pin_din_i(pin_din), .pin_rxclk_i(pin_rxclk), .pin_dcd_i(pin_dcd),
        .tx_data_i(tx_data), .tx_clk_i(tx_clk), .tx_rts_i(tx_rts),
        .rx_data_o(rx_data), .rx_strobe_o(rx_strobe),
        .sout_o(sout), .clkout_o(clkout), .rts_o(rts)
    );

    // pin history as seen at each system edge: index k = k edges ago
    always @(posedge clk) begin
        h_din   <= {h_din[2:0], pin_din};
        h_clk   <= {h_clk[2:0], pin_rxclk};
        h_cd    <= {h_cd[2:0], pin_dcd};
        h_tclk  <= {h_tclk[0], tx_clk};
        h_tdata <= tx_data;
    end

    // 0 direct, 1 echo, 2 loop, 3 muted
    function automatic int exp_state(logic [7:0] c, logic [1:0] m);
        logic [7:0] e;
        e = c[7] ? c : 8'h00;
        if (m[1]) return 2;
        if (e[2]) return 3;
        if (m[0]) return 1;
        return 0;
    endfunction

    function automatic logic exp_data(logic [7:0] c, logic [1:0] m);
        logic [7:0] e;
        int st;
        e = c[7] ? c : 8'h00;
        st = exp_state(c, m);
        if (st == 2) return h_tdata;
        if (st == 3) return 1'b1;
        return h_din[2] ^ e[6];
    endfunction

    function automatic logic exp_strobe(logic [7:0] c, logic [1:0] m);
        logic [7:0] e;
        logic edge_ok, gate_ok;
        int st;
        e = c[7] ? c : 8'h00;
        st = exp_state(c, m);
        if (st == 2) return h_tclk[0] & ~h_tclk[1];
        if (st == 3) return 1'b0;
        edge_ok = e[5] ? (h_clk[3] & ~h_clk[2]) : (~h_clk[3] & h_clk[2]);
        gate_ok = !e[4] || (h_cd[3] == e[3]);
        return edge_ok & gate_ok;
    endfunction

    function automatic string auto_tag(logic [7:0] c, logic [1:0] m, bit is_strobe);
        logic [7:0] e;
        int st;
        e = c[7] ? c : 8'h00;
        st = exp_state(c, m);
        if (st == 2) return "R8";
        if (st == 3) return "R6";
        if (!c[7]) return "R2";
        if (is_strobe) return e[4] ? "R5" : "R4";
        return "R3";
    endfunction

    task automatic chk(string tag, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic drive_random();
        if ($urandom_range(1, 0) == 1) pin_rxclk = ~pin_rxclk;
        pin_din = 1'($urandom_range(1, 0));
        if ($urandom_range(3, 0) == 0) pin_dcd = ~pin_dcd;
        if ($urandom_range(1, 0) == 1) tx_clk = ~tx_clk;
        tx_data = 1'($urandom_range(1, 0));
        tx_rts  = 1'($urandom_range(1, 0));
    endtask

    task automatic run_seg(bit wr, logic [7:0] val, logic [1:0] md, int cycles, string tag);
        string td, ts, te;
        int st;
        @(negedge clk);
        if (wr) begin
            cfg_we = 1'b1;
            cfg_wdata = val;
            cur_cfg = val;
        end
        mode = md;
        cur_mode = md;
        @(negedge clk);
        cfg_we = 1'b0;
        st = exp_state(cur_cfg, cur_mode);
        td = (tag != "") ? tag : auto_tag(cur_cfg, cur_mode, 1'b0);
        ts = (tag != "") ? tag : auto_tag(cur_cfg, cur_mode, 1'b1);
        te = (tag != "") ? tag : ((st == 3 && cur_mode == 2'b01) ? "R9" : "R7");
        for (int i = 0; i < cycles; i++) begin
            if (i >= 4) begin
                chk(td, "rx_data", rx_data, exp_data(cur_cfg, cur_mode));
                chk(ts, "rx_strobe", rx_strobe, exp_strobe(cur_cfg, cur_mode));
            end
            drive_random();
            #1;
            if (i >= 4) begin
                chk(te, "sout", sout, (st == 1) ? pin_din : tx_data);
                chk(te, "clkout", clkout, (st == 1) ? pin_rxclk : tx_clk);
                chk(te, "rts", rts, (st == 1) ? pin_dcd : tx_rts);
            end
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset values visible while reset is held and just after
        chk("R1", "rx_data reset", rx_data, 1'b1);
        chk("R1", "rx_strobe reset", rx_strobe, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "rx_data after reset", rx_data, 1'b1);
        chk("R1", "rx_strobe after reset", rx_strobe, 1'b0);
        // R1: default byte behaves as plain path
        run_seg(1'b0, 8'h00, 2'b00, 60, "R1");
        // R2: feature bits ignored when sync enable is clear
        run_seg(1'b1, 8'h7C, 2'b00, 60, "R2");
        run_seg(1'b1, 8'h7F, 2'b01, 40, "");
        // R3: data inversion and latency
        run_seg(1'b1, 8'hC0, 2'b00, 60, "R3");
        run_seg(1'b1, 8'h80, 2'b00, 40, "R3");
        // R4: falling edges
        run_seg(1'b1, 8'hA0, 2'b00, 60, "R4");
        // R5: carrier gate, both levels
        run_seg(1'b1, 8'h90, 2'b00, 80, "R5");
        run_seg(1'b1, 8'h98, 2'b00, 80, "R5");
        run_seg(1'b1, 8'hB8, 2'b00, 80, "R5");
        // R6: inputs disabled
        run_seg(1'b1, 8'h84, 2'b00, 40, "R6");
        run_seg(1'b1, 8'hFC, 2'b00, 40, "R6");
        // R7: echo with every polarity bit set
        run_seg(1'b1, 8'hF8, 2'b01, 60, "R7");
        // R8: loopback ignores polarity and input disable
        run_seg(1'b1, 8'hF8, 2'b10, 60, "R8");
        run_seg(1'b1, 8'hFC, 2'b11, 60, "R8");
        // R9: priority corners
        run_seg(1'b1, 8'h84, 2'b01, 40, "R9");
        run_seg(1'b1, 8'h84, 2'b11, 40, "R9");
        // random segments
        for (int s = 0; s < 80; s++) begin
            run_seg(1'b1, 8'($urandom_range(255, 0)), 2'($urandom_range(3, 0)), 40, "");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule